// File: doc/BRIEF.md
# Priority Interrupt Grant Controller

This block sits on the processor side of a vectored interrupt bus. A row of modelled device slots each holds a pending request at one of four urgency levels (4 to 7) together with a vector address. The pending slots drive four level-sensitive request lines. The controller compares those lines with the 3-bit current priority taken from the status word. It raises a single grant, for the most urgent line whose level is strictly above that priority.

The grant travels serially down the slot chain, starting at the slot nearest the processor. A slot that is requesting at the granted level keeps the grant, clears its own request and offers its vector address. A slot that is idle, or requesting at another level, hands the grant on. The controller registers the vector and presents it to a trap sequencer with a valid flag. It holds the vector until the sequencer accepts it. If no slot takes the grant within a fixed number of cycles, the controller presents the bus-error vector (address 4) instead, and flags a timeout. Pushing the old PC and status word and loading the new status word are left to the trap sequencer.

Top module: `irq_grant_ctrl`

## Requirements
- R1: After reset no grant is active, the vector valid, odd and timeout flags are low, and no slot is pending.
- R2: A grant is issued only for a level strictly above `cur_pri_i`. At priority 7 nothing is granted. At priority 3 or below every level from 4 to 7 can be granted.
- R3: When several eligible lines are asserted, the grant goes to the highest level. `grant_o` bit i stands for level 4+i, and the slot level code c in `slot_lvl_i` means level 4+c.
- R4: A request that is not granted stays pending, and its line stays asserted, until the slot is served. A lower priority later lets it through.
- R5: Among slots pending at the granted level, the one with the lowest index (nearest the processor) captures the grant. The others stay pending.
- R6: The capturing slot clears its own request on the capture edge. One cycle after the grant appears, `vec_valid_o` rises with that slot's vector on `vec_addr_o`.
- R7: At most one grant bit is high at any time. The grant and the vector stay unchanged until `vec_taken_i` is seen with the vector valid. After that edge both drop.
- R8: A request that arrives while a grant is outstanding does not pre-empt it, even at a higher level. It is arbitrated on the cycle after the current grant completes.
- R9: If no slot captures the grant within TIMEOUT cycles (default 16), the vector becomes valid with address 4 and `timeout_o` high, exactly TIMEOUT cycles after the grant appears.
- R10: A captured vector with bit 0 set is flagged with `vec_odd_o` for as long as it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pri_i | input | 3 | Current processor priority |
| slot_set_i | input | NUM_SLOTS | Pulse per slot: raise its request |
| slot_drop_i | input | NUM_SLOTS | Pulse per slot: withdraw its request |
| slot_lvl_i | input | 2*NUM_SLOTS | Per-slot level code (level = 4 + code) |
| slot_vec_i | input | VEC_W*NUM_SLOTS | Per-slot vector address |
| vec_taken_i | input | 1 | Trap sequencer accepts the presented vector |
| bus_req_o | output | 4 | Request lines, bit i = level 4+i |
| slot_pend_o | output | NUM_SLOTS | Pending request state per slot |
| grant_o | output | 4 | Active grant, one-hot, bit i = level 4+i |
| vec_valid_o | output | 1 | Vector address is valid |
| vec_addr_o | output | VEC_W | Vector address for the trap sequencer |
| vec_odd_o | output | 1 | Presented vector is odd (protocol error) |
| timeout_o | output | 1 | Vector is the bus-error vector after no answer |

## Verification
A wrong arbitration decision shows on `grant_o` one cycle after the request lines settle: the wrong level, or a grant against the priority. A broken chain shows one cycle later, as a wrong vector address or as the wrong bits left in `slot_pend_o`. A stuck or miscounting timeout counter shifts the bus-error vector away from its exact cycle. A grant state that is not held correctly appears as a grant changing, or re-arbitrating, before the vector is taken.

// File: rtl/igc_pkg.sv
package igc_pkg;
  localparam int LINES      = 4;
  localparam int BASE_LEVEL = 4;
  localparam int PRI_W      = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_VEC   = 2'd2
  } igc_state_e;
endpackage

// File: rtl/igc_arbiter.sv
module igc_arbiter
  import igc_pkg::*;
(
  input  logic [LINES-1:0] line_req_i,
  input  logic [PRI_W-1:0] pri_i,
  output logic [LINES-1:0] pick_o,
  output logic             any_o
);
  logic [LINES-1:0] elig;

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_elig
      assign elig[i] = line_req_i[i] && ((BASE_LEVEL + i) > int'(pri_i));
    end
  endgenerate

  // highest eligible line wins: scan upward, last hit is kept
  always_comb begin
    pick_o = '0;
    for (int i = 0; i < LINES; i++) begin
      if (elig[i]) begin
        pick_o    = '0;
        pick_o[i] = 1'b1;
      end
    end
  end

  assign any_o = |elig;
endmodule

// File: rtl/igc_slot.sv
module igc_slot
  import igc_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic             drop_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LINES-1:0] gnt_lvl_i,
  input  logic             gnt_in_i,
  output logic             gnt_out_o,
  output logic             capture_o,
  output logic             pend_o,
  output logic [LINES-1:0] line_o
);
  logic pend_q;
  logic match;

  assign match     = pend_q && gnt_lvl_i[lvl_i];
  assign capture_o = gnt_in_i && match;
  assign gnt_out_o = gnt_in_i && !match;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (capture_o || drop_i) pend_q <= 1'b0;
  end

  always_comb begin
    line_o = '0;
    line_o[lvl_i] = pend_q;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/igc_timer.sv
module igc_timer #(
  parameter int LIMIT = 16,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irq_grant_ctrl.sv
module irq_grant_ctrl
  import igc_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int VEC_W     = 16,
  parameter int TIMEOUT   = 16,
  parameter int BUSERR_VEC = 4,
  localparam int LVL_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [PRI_W-1:0]           cur_pri_i,
  input  logic [NUM_SLOTS-1:0]       slot_set_i,
  input  logic [NUM_SLOTS-1:0]       slot_drop_i,
  input  logic [LVL_W*NUM_SLOTS-1:0] slot_lvl_i,
  input  logic [VEC_W*NUM_SLOTS-1:0] slot_vec_i,
  input  logic                       vec_taken_i,
  output logic [LINES-1:0]           bus_req_o,
  output logic [NUM_SLOTS-1:0]       slot_pend_o,
  output logic [LINES-1:0]           grant_o,
  output logic                       vec_valid_o,
  output logic [VEC_W-1:0]           vec_addr_o,
  output logic                       vec_odd_o,
  output logic                       timeout_o
);
  igc_state_e       state_q;
  logic [LINES-1:0] grant_q;
  logic [LINES-1:0] pick;
  logic             pick_any;
  logic             chain_en;
  logic             expire;
  logic [NUM_SLOTS:0]   chain;
  logic [NUM_SLOTS-1:0] capture;
  logic [LINES-1:0]     slot_lines [NUM_SLOTS];
  logic [VEC_W-1:0]     cap_vec;
  logic                 cap_any;

  assign chain_en = (state_q == ST_GRANT);
  assign chain[0] = chain_en;

  generate
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      igc_slot #(.LVL_W(LVL_W)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .set_i     (slot_set_i[k]),
        .drop_i    (slot_drop_i[k]),
        .lvl_i     (slot_lvl_i[k*LVL_W +: LVL_W]),
        .gnt_lvl_i (grant_q),
        .gnt_in_i  (chain[k]),
        .gnt_out_o (chain[k+1]),
        .capture_o (capture[k]),
        .pend_o    (slot_pend_o[k]),
        .line_o    (slot_lines[k])
      );
    end
  endgenerate

  always_comb begin
    bus_req_o = '0;
    cap_vec   = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      bus_req_o = bus_req_o | slot_lines[k];
      if (capture[k]) cap_vec = cap_vec | slot_vec_i[k*VEC_W +: VEC_W];
    end
  end
  assign cap_any = |capture;

  igc_arbiter u_arb (
    .line_req_i (bus_req_o),
    .pri_i      (cur_pri_i),
    .pick_o     (pick),
    .any_o      (pick_any)
  );

  igc_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .run_i    (chain_en && !cap_any),
    .expire_o (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      grant_q     <= '0;
      vec_valid_o <= 1'b0;
      vec_addr_o  <= '0;
      vec_odd_o   <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pick_any) begin
            grant_q <= pick;
            state_q <= ST_GRANT;
          end
        end
        ST_GRANT: begin
          if (cap_any) begin
            vec_valid_o <= 1'b1;
            vec_addr_o  <= cap_vec;
            vec_odd_o   <= cap_vec[0];
            timeout_o   <= 1'b0;
            state_q     <= ST_VEC;
          end else if (expire) begin
            vec_valid_o <= 1'b1;
            vec_addr_o  <= VEC_W'(BUSERR_VEC);
            vec_odd_o   <= 1'b0;
            timeout_o   <= 1'b1;
            state_q     <= ST_VEC;
          end
        end
        ST_VEC: begin
          if (vec_taken_i) begin
            vec_valid_o <= 1'b0;
            vec_odd_o   <= 1'b0;
            timeout_o   <= 1'b0;
            grant_q     <= '0;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/igc_checker.sv
module igc_checker #(
  parameter int VEC_W   = 16,
  parameter int TIMEOUT = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       cur_pri_i,
  input logic             vec_taken_i,
  input logic [3:0]       grant_o,
  input logic             vec_valid_o,
  input logic [VEC_W-1:0] vec_addr_o,
  input logic             timeout_o
);
  int glvl;
  int wait_cnt;

  always_comb begin
    glvl = 0;
    for (int i = 0; i < 4; i++) if (grant_o[i]) glvl = 4 + i;
  end

  always_ff @(posedge clk) begin
    if (rst || grant_o == 4'b0 || vec_valid_o) wait_cnt <= 0;
    else wait_cnt <= wait_cnt + 1;
  end

  // R2
  pri_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_o != 4'b0 && $past(grant_o) == 4'b0) |-> (glvl > int'($past(cur_pri_i))));

  // R7
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  // R7
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_valid_o && !vec_taken_i) |=> (vec_valid_o && $stable(vec_addr_o) && $stable(grant_o)));

  // R8
  no_preempt_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_o != 4'b0 && !(vec_valid_o && vec_taken_i)) |=> $stable(grant_o));

  // R9
  buserr_vec_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (vec_valid_o && vec_addr_o == VEC_W'(4)));

  // R9
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    wait_cnt <= TIMEOUT);

  // R6
  vec_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> grant_o != 4'b0);
endmodule

bind irq_grant_ctrl igc_checker #(.VEC_W(VEC_W), .TIMEOUT(TIMEOUT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cur_pri_i   (cur_pri_i),
  .vec_taken_i (vec_taken_i),
  .grant_o     (grant_o),
  .vec_valid_o (vec_valid_o),
  .vec_addr_o  (vec_addr_o),
  .timeout_o   (timeout_o)
);

// File: tb/irq_grant_ctrl_test.sv
module irq_grant_ctrl_test;
  localparam int N  = 4;
  localparam int VW = 16;
  localparam int TO = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    cur_pri_i;
  logic [N-1:0]  slot_set_i, slot_drop_i;
  logic [2*N-1:0]  slot_lvl_i;
  logic [VW*N-1:0] slot_vec_i;
  logic          vec_taken_i;
  logic [3:0]    bus_req_o;
  logic [N-1:0]  slot_pend_o;
  logic [3:0]    grant_o;
  logic          vec_valid_o;
  logic [VW-1:0] vec_addr_o;
  logic          vec_odd_o, timeout_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_grant_ctrl #(.NUM_SLOTS(N), .VEC_W(VW), .TIMEOUT(TO)) uut (
    .clk(clk), .rst(rst), .cur_pri_i(cur_pri_i),
    .slot_set_i(slot_set_i), .slot_drop_i(slot_drop_i),
    .slot_lvl_i(slot_lvl_i), .slot_vec_i(slot_vec_i),
    .vec_taken_i(vec_taken_i), .bus_req_o(bus_req_o),
    .slot_pend_o(slot_pend_o), .grant_o(grant_o),
    .vec_valid_o(vec_valid_o), .vec_addr_o(vec_addr_o),
    .vec_odd_o(vec_odd_o), .timeout_o(timeout_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pulse set on a slot mask; returns after the pending flops are loaded
  task automatic raise(input logic [N-1:0] m);
    slot_set_i = m;
    step(1);
    slot_set_i = '0;
  endtask

  task automatic take();
    vec_taken_i = 1'b1;
    step(1);
    vec_taken_i = 1'b0;
  endtask

  // slot levels: s0=5, s1=7, s2=5, s3=4
  task automatic config_slots(input logic [VW-1:0] v3);
    slot_lvl_i = {2'd0, 2'd1, 2'd3, 2'd1};
    slot_vec_i = {v3, 16'h0080, 16'h0070, 16'h0060};
  endtask

  task automatic t_reset();
    chk("R1 grant", grant_o, 0);
    chk("R1 valid", {vec_valid_o, vec_odd_o, timeout_o}, 0);
    chk("R1 pend", slot_pend_o, 0);
  endtask

  task automatic t_priority_gate();
    cur_pri_i = 3'd7;
    raise(4'b0010);              // level 7
    step(5);
    chk("R2 pri7 no grant", grant_o, 0);
    chk("R4 line held", bus_req_o, 4'b1000);
    chk("R4 still pending", slot_pend_o, 4'b0010);
    cur_pri_i = 3'd6;
    step(1);
    chk("R2 granted above 6", grant_o, 4'b1000);
    step(1);
    chk("R6 vec valid", vec_valid_o, 1);
    chk("R6 vec addr", vec_addr_o, 16'h0070);
    chk("R6 request released", slot_pend_o, 0);
    take();
    chk("R7 grant dropped", {grant_o, vec_valid_o}, 0);
    // equal level is not above priority
    cur_pri_i = 3'd5;
    raise(4'b0001);              // level 5
    step(3);
    chk("R2 equal level blocked", grant_o, 0);
    cur_pri_i = 3'd4;
    step(1);
    chk("R2 level5 above 4", grant_o, 4'b0010);
    step(1);
    chk("R6 slot0 vec", vec_addr_o, 16'h0060);
    take();
  endtask

  task automatic t_highest();
    cur_pri_i = 3'd0;
    raise(4'b1010);              // levels 4 and 7
    step(1);
    chk("R3 highest level", grant_o, 4'b1000);
    step(1);
    chk("R3 vec of level7", vec_addr_o, 16'h0070);
    take();
    step(1);
    chk("R3 next level4", grant_o, 4'b0001);
    step(1);
    chk("R3 vec of level4", vec_addr_o, 16'h0090);
    take();
  endtask

  task automatic t_chain();
    cur_pri_i = 3'd3;
    raise(4'b0101);              // s0 and s2 both level 5
    step(1);
    chk("R5 grant level5", grant_o, 4'b0010);
    step(1);
    chk("R5 nearest slot vec", vec_addr_o, 16'h0060);
    chk("R5 far slot pending", slot_pend_o, 4'b0100);
    take();
    step(2);
    chk("R5 far slot served", vec_addr_o, 16'h0080);
    chk("R5 all served", slot_pend_o, 0);
    take();
  endtask

  task automatic t_no_preempt();
    cur_pri_i = 3'd0;
    raise(4'b1000);              // level 4
    step(1);
    chk("R8 low grant", grant_o, 4'b0001);
    raise(4'b0010);              // level 7 arrives during grant
    step(3);
    chk("R8 grant kept", grant_o, 4'b0001);
    chk("R7 vec held", {vec_valid_o, vec_addr_o}, {1'b1, 16'h0090});
    chk("R8 high pending", slot_pend_o, 4'b0010);
    take();
    chk("R8 idle after take", grant_o, 0);
    step(1);
    chk("R8 high granted next", grant_o, 4'b1000);
    step(1);
    take();
  endtask

  task automatic t_timeout();
    cur_pri_i = 3'd0;
    raise(4'b0001);
    slot_drop_i = 4'b0001;       // withdraw on the granting edge
    step(1);
    slot_drop_i = '0;
    chk("R9 grant issued", grant_o, 4'b0010);
    step(TO - 1);
    chk("R9 not yet timed out", vec_valid_o, 0);
    step(1);
    chk("R9 timeout vec", {vec_valid_o, timeout_o, vec_addr_o}, {1'b1, 1'b1, 16'h0004});
    take();
    chk("R9 cleared", {grant_o, timeout_o}, 0);
  endtask

  task automatic t_odd();
    config_slots(16'h0093);
    cur_pri_i = 3'd0;
    raise(4'b1000);
    step(2);
    chk("R10 odd flag", {vec_odd_o, vec_addr_o}, {1'b1, 16'h0093});
    step(2);
    chk("R10 odd held", vec_odd_o, 1);
    take();
    chk("R10 odd cleared", vec_odd_o, 0);
  endtask

  initial begin
    rst = 1'b1;
    cur_pri_i = 3'd7;
    slot_set_i = '0;
    slot_drop_i = '0;
    vec_taken_i = 1'b0;
    config_slots(16'h0090);
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_priority_gate();
    t_highest();
    t_chain();
    t_no_preempt();
    t_timeout();
    t_odd();
    step(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule